// File: doc/BRIEF.md
# NRZI Symbol Serializer/Deserializer with Loopback

This block sits between a physical coding layer that works on 5-bit code-groups and a single-wire line. On the transmit side it takes one code-group every five cycles of its clock, sends the bits one per cycle with the most significant bit first, and encodes the serial stream as NRZI. The clock `clk` runs at the bit rate, five times the symbol rate: a 25 MHz symbol rate gives 125 Mbps on the line. On the receive side it decodes NRZI from the line and groups the bits into 5-bit symbols at a fixed phase of its own symbol counter, with no search for code-group boundaries. Framing is left to the layer above.

A two-bit mode input selects one of two loopback points. Parallel loopback returns the most recently loaded transmit symbol straight to the receive symbol output. Serial loopback feeds the NRZI transmit line into the NRZI decoder in place of the external receive line. In both loopback modes the external receive line is ignored and the transmit line keeps running.

Symbol phase is kept by a two-state machine. `PH_LOAD` lasts one cycle; in it `sym_strobe` is high and the next symbol is captured. Transition `PH_LOAD -> PH_SHIFT` is taken on every edge. `PH_SHIFT` lasts four cycles, counted 1 to 4. Transition `PH_SHIFT -> PH_LOAD` is taken when the count reaches 4, and otherwise the machine stays in `PH_SHIFT` with the count incremented. Reset enters `PH_LOAD`.

Top module: `nrzi_serdes_lb`

## Requirements
- R1: While `rst_n` is low, `line_tx`, `rx_valid` and `rx_sym` are all 0. The first rising edge after reset is a load edge.
- R2: `sym_strobe` is high for exactly one cycle in every five. `tx_sym` is captured on the rising edge that ends a cycle in which `sym_strobe` is high (the load edge).
- R3: A captured symbol is sent on the five rising edges that follow its load edge, bit 4 on the first and bit 0 on the last.
- R4: On each edge that carries a 1 bit, `line_tx` toggles. On each edge that carries a 0 bit, it holds its level. A stream of 00000 symbols leaves the line constant, and a stream of 11111 symbols toggles it every cycle.
- R5: `rx_valid` is a one-cycle pulse in the cycle after the edge that follows each load edge, so it comes two cycles after each `sym_strobe` cycle.
- R6: With `lb_mode` = 2'b00, each bit is the XOR of `line_rx` with its level one edge earlier. The bits sampled on the 2nd through 6th edges after a load edge form the symbol, the first one received in bit 4. That symbol is shown with the pulse that follows the next load edge.
- R7: With `lb_mode` = 2'b01 (parallel loopback), `rx_sym` shown with a pulse equals the symbol captured at the load edge just before it, and `line_rx` is ignored.
- R8: With `lb_mode` = 2'b10 (serial loopback), the decoder reads `line_tx` in place of `line_rx`. `rx_sym` shown with a pulse equals the symbol captured one load edge earlier than in R7, and `line_rx` is ignored.
- R9: `lb_mode` = 2'b11 behaves exactly like 2'b00.
- R10: `rx_sym` changes only at the edge that starts an `rx_valid` pulse, and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, five cycles per symbol |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_mode | input | 2 | 00 normal, 01 parallel loopback, 10 serial loopback, 11 normal |
| tx_sym | input | SYM_W | Transmit code-group, captured at the load edge |
| sym_strobe | output | 1 | High in the cycle whose ending edge captures `tx_sym` |
| line_tx | output | 1 | NRZI serial transmit line |
| line_rx | input | 1 | NRZI serial receive line |
| rx_sym | output | SYM_W | Unframed received symbol |
| rx_valid | output | 1 | One-cycle pulse marking a new `rx_sym` |

## Verification
The assertions check on every cycle the five-cycle strobe spacing, the placement and one-cycle width of `rx_valid` relative to the strobe, the holding of `rx_sym` between pulses, and, once the mode has been steady long enough, the symbol each loopback returns against the `tx_sym` seen two or seven cycles earlier. Only the bench scenarios can show that the line really carries NRZI with MSB first, since they decode `line_tx` independently. They also feed a separately encoded stream on `line_rx` to confirm the fixed-phase grouping in the normal modes, and scramble `line_rx` during loopback to show it is ignored. Reset in the middle of a stream is likewise covered only by the bench.

// File: rtl/nrzi_lb_pkg.sv
package nrzi_lb_pkg;
    localparam int unsigned SYM_BITS = 5;

    typedef enum logic [1:0] {
        LB_NONE = 2'b00,
        LB_PAR  = 2'b01,
        LB_SER  = 2'b10,
        LB_ALT  = 2'b11
    } lb_mode_e;

    typedef enum logic {
        PH_LOAD  = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;
endpackage

// File: rtl/sym_phase_fsm.sv
module sym_phase_fsm
    import nrzi_lb_pkg::*;
#(
    parameter int unsigned SYM_W = SYM_BITS
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_en,
    output logic cap_en
);
    localparam int unsigned CW = (SYM_W > 2) ? $clog2(SYM_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);
    localparam logic [CW-1:0] ONE  = CW'(1);

    phase_e        st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= PH_LOAD;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PH_LOAD: begin
                st_d  = PH_SHIFT;
                cnt_d = ONE;
            end
            PH_SHIFT: begin
                if (cnt_q == LAST) begin
                    st_d  = PH_LOAD;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            default: begin
                st_d  = PH_LOAD;
                cnt_d = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        load_en = 1'b0;
        cap_en  = 1'b0;
        unique case (st_q)
            PH_LOAD:  load_en = 1'b1;
            PH_SHIFT: cap_en  = (cnt_q == ONE);
            default:  load_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/nrzi_tx_ser.sv
module nrzi_tx_ser #(
    parameter int unsigned SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [SYM_W-1:0] sym_in,
    output logic             line_o,
    output logic [SYM_W-1:0] hold_o
);
    logic [SYM_W-1:0] shreg_q;
    logic [SYM_W-1:0] hold_q;
    logic             line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            hold_q  <= '0;
            line_q  <= 1'b0;
        end else begin
            // a one flips the line level, a zero keeps it
            line_q <= line_q ^ shreg_q[SYM_W-1];
            if (load_en) begin
                shreg_q <= sym_in;
                hold_q  <= sym_in;
            end else begin
                shreg_q <= {shreg_q[SYM_W-2:0], 1'b0};
            end
        end
    end

    assign line_o = line_q;
    assign hold_o = hold_q;
endmodule

// File: rtl/nrzi_rx_des.sv
module nrzi_rx_des #(
    parameter int unsigned SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             line_i,
    input  logic             par_en,
    input  logic [SYM_W-1:0] par_sym,
    output logic [SYM_W-1:0] sym_o,
    output logic             valid_o
);
    logic             prev_q;
    logic [SYM_W-2:0] sh_q;
    logic [SYM_W-1:0] sym_q;
    logic             valid_q;
    logic             bit_w;
    logic [SYM_W-1:0] word_w;

    // a level change since the last edge decodes as a one
    assign bit_w  = line_i ^ prev_q;
    assign word_w = {sh_q, bit_w};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            sh_q    <= '0;
            sym_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            prev_q  <= line_i;
            sh_q    <= word_w[SYM_W-2:0];
            valid_q <= cap_en;
            if (cap_en) begin
                sym_q <= par_en ? par_sym : word_w;
            end
        end
    end

    assign sym_o   = sym_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/nrzi_serdes_lb.sv
module nrzi_serdes_lb
    import nrzi_lb_pkg::*;
#(
    parameter int unsigned SYM_W = SYM_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       lb_mode,
    input  logic [SYM_W-1:0] tx_sym,
    output logic             sym_strobe,
    output logic             line_tx,
    input  logic             line_rx,
    output logic [SYM_W-1:0] rx_sym,
    output logic             rx_valid
);
    lb_mode_e         mode_w;
    logic             load_en;
    logic             cap_en;
    logic             par_sel;
    logic             ser_sel;
    logic             dec_line;
    logic             tx_line;
    logic [SYM_W-1:0] tx_hold;

    assign mode_w  = lb_mode_e'(lb_mode);
    assign par_sel = (mode_w == LB_PAR);
    assign ser_sel = (mode_w == LB_SER);

    sym_phase_fsm #(.SYM_W(SYM_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .cap_en  (cap_en)
    );

    nrzi_tx_ser #(.SYM_W(SYM_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .sym_in  (tx_sym),
        .line_o  (tx_line),
        .hold_o  (tx_hold)
    );

    assign dec_line = ser_sel ? tx_line : line_rx;

    nrzi_rx_des #(.SYM_W(SYM_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .line_i  (dec_line),
        .par_en  (par_sel),
        .par_sym (tx_hold),
        .sym_o   (rx_sym),
        .valid_o (rx_valid)
    );

    assign sym_strobe = load_en;
    assign line_tx    = tx_line;
endmodule

// File: rtl/nrzi_serdes_lb_chk.sv
module nrzi_serdes_lb_chk
    import nrzi_lb_pkg::*;
#(
    parameter int unsigned SYM_W = SYM_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       lb_mode,
    input logic [SYM_W-1:0] tx_sym,
    input logic             sym_strobe,
    input logic [SYM_W-1:0] rx_sym,
    input logic             rx_valid
);
    logic [7:0] gap_q;
    logic       seen_q;
    logic [1:0] mode_q;
    logic [3:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
            mode_q <= '0;
            age_q  <= '0;
        end else begin
            if (sym_strobe) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 8'd1;
            end
            mode_q <= lb_mode;
            if (lb_mode != mode_q) age_q <= '0;
            else if (age_q != 4'hF) age_q <= age_q + 4'd1;
        end
    end

    // R2
    strobe_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (sym_strobe == (gap_q == 8'(SYM_W - 1))));

    // R5
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(sym_strobe, 2));

    // R5
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_sym));

    // R7
    par_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && lb_mode_e'(lb_mode) == LB_PAR && age_q >= 4'd2)
        |-> (rx_sym == $past(tx_sym, 2)));

    // R8
    ser_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && lb_mode_e'(lb_mode) == LB_SER && age_q >= 4'd8)
        |-> (rx_sym == $past(tx_sym, 7)));
endmodule

bind nrzi_serdes_lb nrzi_serdes_lb_chk #(.SYM_W(SYM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lb_mode    (lb_mode),
    .tx_sym     (tx_sym),
    .sym_strobe (sym_strobe),
    .rx_sym     (rx_sym),
    .rx_valid   (rx_valid)
);

// File: tb/tb_nrzi_serdes_lb.sv
module tb_nrzi_serdes_lb;
    localparam int CLK_PERIOD = 8;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lb_mode = 2'b00;
    logic [SW-1:0] tx_sym = '0;
    logic          sym_strobe;
    logic          line_tx;
    logic          line_rx = 1'b0;
    logic [SW-1:0] rx_sym;
    logic          rx_valid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    // bench model state
    int            cyc;
    int            nstrobe;
    int            kidx;
    int            eidx;
    int            pat;
    int            settle;
    logic [SW-1:0] cur_sym, prev_sym, ext_cur, last_rx, tx_acc;
    logic          tx_lvl, ext_lvl;
    logic [15:0]   lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    nrzi_serdes_lb dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lb_mode    (lb_mode),
        .tx_sym     (tx_sym),
        .sym_strobe (sym_strobe),
        .line_tx    (line_tx),
        .line_rx    (line_rx),
        .rx_sym     (rx_sym),
        .rx_valid   (rx_valid)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] gen_tx(input int p, input int k);
        case (p)
            0: return 5'b00000;
            1: return 5'b11111;
            2: return 5'((k * 7 + 3) & 31);
            3: return (k % 2 == 0) ? 5'b10101 : 5'b01010;
            default: return 5'(1 << (k % 5));
        endcase
    endfunction

    // one bit cycle: sample at the falling edge, then drive
    task automatic step();
        int   cs;
        int   pos;
        logic dbit;
        logic [SW-1:0] exp_rx;
        @(negedge clk);
        cs = (cyc + 1) % 5;
        cyc = cs;
        pos = (cs + 3) % 5;
        // R2 strobe phase
        if (nstrobe >= 1)
            chk(sym_strobe == (cs == 0), "R2 strobe phase", int'(sym_strobe), int'(cs == 0));
        // R3 R4 independent NRZI decode of line_tx
        dbit = line_tx ^ tx_lvl;
        tx_lvl = line_tx;
        tx_acc[SW-1-pos] = dbit;
        if (cs == 1 && nstrobe >= 2)
            chk(tx_acc == prev_sym, "R3 R4 decoded tx symbol", int'(tx_acc), int'(prev_sym));
        // R5 pulse placement
        chk(rx_valid == (cs == 2), "R5 rx_valid timing", int'(rx_valid), int'(cs == 2));
        // R10 hold between pulses
        if (!rx_valid)
            chk(rx_sym == last_rx, "R10 rx_sym hold", int'(rx_sym), int'(last_rx));
        else
            last_rx = rx_sym;
        // received symbol content
        if (rx_valid && settle == 0) begin
            case (lb_mode)
                2'b01: begin
                    exp_rx = cur_sym;
                    chk(rx_sym == exp_rx, "R7 parallel loopback", int'(rx_sym), int'(exp_rx));
                end
                2'b10: begin
                    exp_rx = prev_sym;
                    chk(rx_sym == exp_rx, "R8 serial loopback", int'(rx_sym), int'(exp_rx));
                end
                2'b11: begin
                    exp_rx = ext_cur;
                    chk(rx_sym == exp_rx, "R9 mode 11 as normal", int'(rx_sym), int'(exp_rx));
                end
                default: begin
                    exp_rx = ext_cur;
                    chk(rx_sym == exp_rx, "R6 normal receive", int'(rx_sym), int'(exp_rx));
                end
            endcase
        end
        if (settle > 0) settle--;
        // drive transmit symbol
        if (cs == 0) begin
            prev_sym = cur_sym;
            cur_sym  = gen_tx(pat, kidx);
            tx_sym   = cur_sym;
            kidx++;
            nstrobe++;
        end
        // drive receive line
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (lb_mode == 2'b00 || lb_mode == 2'b11) begin
            if (cs == 2) begin
                ext_cur = 5'((eidx * 11 + 5) & 31);
                eidx++;
            end
            ext_lvl = ext_lvl ^ ext_cur[SW-1-pos];
            line_rx = ext_lvl;
        end else begin
            line_rx = lfsr[0];
            ext_lvl = lfsr[0];
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_mode(input logic [1:0] m);
        lb_mode = m;
        settle = 12;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_sym = '0;
        line_rx = 1'b0;
        repeat (3) @(negedge clk);
        chk(line_tx == 1'b0, "R1 line_tx in reset", int'(line_tx), 0);
        chk(rx_valid == 1'b0, "R1 rx_valid in reset", int'(rx_valid), 0);
        chk(rx_sym == '0, "R1 rx_sym in reset", int'(rx_sym), 0);
        rst_n = 1'b1;
        cyc = 0; nstrobe = 1; kidx = 0; eidx = 0;
        cur_sym = '0; prev_sym = '0; ext_cur = '0; last_rx = '0; tx_acc = '0;
        tx_lvl = 1'b0; ext_lvl = 1'b0;
        settle = 12;
    endtask

    task automatic test_normal_patterns();
        set_mode(2'b00);
        for (int p = 1; p <= 4; p++) begin
            pat = p;
            run(30);
        end
    endtask

    task automatic test_zero_hold();
        logic lvl;
        pat = 0;
        run(12);
        lvl = line_tx;
        for (int i = 0; i < 10; i++) begin
            step();
            chk(line_tx == lvl, "R4 zero symbols hold line", int'(line_tx), int'(lvl));
        end
    endtask

    task automatic test_ones_toggle();
        logic lvl;
        pat = 1;
        run(12);
        for (int i = 0; i < 10; i++) begin
            lvl = line_tx;
            step();
            chk(line_tx != lvl, "R4 one symbols toggle line", int'(line_tx), int'(!lvl));
        end
    endtask

    task automatic test_parallel();
        set_mode(2'b01);
        pat = 2; run(40);
        pat = 4; run(25);
    endtask

    task automatic test_serial();
        set_mode(2'b10);
        pat = 2; run(40);
        pat = 3; run(25);
    endtask

    task automatic test_alt_mode();
        set_mode(2'b11);
        pat = 4; run(35);
    endtask

    task automatic test_midrun_reset();
        set_mode(2'b00);
        pat = 2; run(13);
        do_reset();
        run(30);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        pat = 2;
        do_reset();
        test_normal_patterns();
        test_zero_hold();
        test_ones_toggle();
        test_parallel();
        test_serial();
        test_alt_mode();
        test_midrun_reset();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule